// File: doc/BRIEF.md
# Peripheral Bus Acknowledge Generator

This block sits on the host board and decides when the shared peripheral bus is offered to the expansion cards. Cards that want the bus raise a shared, wired request line. The generator brings that line and the shared busy line into its own clock domain. It then waits for a fixed settling window, so that every contending card has time to raise its request and to block the acknowledge chain. After that window, and once the host memory arbiter gives permission, it drives the acknowledge into the head of the daisy chain at the slot nearest the host.

The card that wins the chain signals its ownership by raising busy. Busy stays high for the card's whole tenure, and the generator removes the acknowledge as soon as it sees busy. If no card claims the bus within a timeout, the acknowledge is withdrawn and the generator goes back to idle. A separate active flag tells the memory arbiter that the peripheral side holds, or is being offered, the memory port. Cards use this bus only to move data to and from main memory; their other service requests go to the host CPU by interrupt and never pass through this block.

Top module: `pbus_ack_gen`

## Requirements
- R1: While reset is applied and after it is released, with no request, `pb_ack_o` and `io_active_o` are 0.
- R2: With `io_grant_ok_i` high and busy low, `pb_ack_o` rises no fewer than SETTLE_CYC + SYNC_STAGES and no more than SETTLE_CYC + SYNC_STAGES + 2 clock cycles after `pb_req_i` rises.
- R3: If `pb_req_i` falls before the settling window has expired, the window restarts in full when the request returns.
- R4: While `io_grant_ok_i` is low, `pb_ack_o` stays low. Once the window has expired, `pb_ack_o` rises within 2 cycles of `io_grant_ok_i` going high.
- R5: `pb_ack_o` falls within SYNC_STAGES + 1 cycles of `pb_busy_i` rising.
- R6: `io_active_o` is high from the rise of `pb_ack_o` until busy falls, and it is low again within SYNC_STAGES + 1 cycles of `pb_busy_i` falling.
- R7: If busy does not rise, `pb_ack_o` stays high for BUSY_TIMEOUT cycles (within one cycle), and then both outputs return to 0.
- R8: While busy is high and no acknowledge is pending, a request does not start the settling window. Once busy falls, the full window runs again before `pb_ack_o` rises.
- R9: During a tenure (busy high after an acknowledge), `pb_ack_o` stays low even though the request is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pb_req_i | input | 1 | Shared bus request from the cards, active high, asynchronous |
| pb_busy_i | input | 1 | Shared busy from the owning card, active high, asynchronous |
| io_grant_ok_i | input | 1 | Permission from the memory arbiter to offer the bus, synchronous |
| pb_ack_o | output | 1 | Acknowledge into the head of the daisy chain |
| io_active_o | output | 1 | Peripheral side is offered or holds the memory port |

## Verification
The assertions assume that the cards behave correctly: a card raises busy only while an acknowledge is offered, or while an earlier tenure is still running. They also assume that busy, once raised, stays high until the tenure ends and does not glitch. They further assume that the permission input is already synchronous to the block clock. The directed stimulus keeps to these rules. It raises busy only after it has seen the acknowledge, or deliberately before any request in the scenario that checks blocking while the bus is held. It changes all inputs half a cycle away from the active edge.

// File: rtl/pbus_ack_pkg.sv
package pbus_ack_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_OFFER  = 2'd2,
    ST_HELD   = 2'd3
  } pbus_state_e;

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[0] <= 1'b0;
          else        sh_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pbus_timer.sv
module pbus_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             zero_o
);
  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                               cnt_d = load_val_i;
    else if (dec_i && (cnt_q != '0))          cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pbus_ack_gen.sv
module pbus_ack_gen
  import pbus_ack_pkg::*;
#(
  parameter int SETTLE_CYC   = 20,
  parameter int BUSY_TIMEOUT = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pb_req_i,
  input  logic pb_busy_i,
  input  logic io_grant_ok_i,
  output logic pb_ack_o,
  output logic io_active_o
);
  localparam int MAXC = (SETTLE_CYC > BUSY_TIMEOUT) ? SETTLE_CYC : BUSY_TIMEOUT;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] TOUT_LD   = TW'(BUSY_TIMEOUT - 1);

  logic rst_n_s, req_s, busy_s;
  logic set_ld, set_dec, set_zero;
  logic to_ld, to_dec, to_zero;
  pbus_state_e state_q, state_d;

  // Reset: asserted asynchronously, released after the synchronizer chain
  pbus_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_s)
  );
  pbus_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(pb_req_i), .q_o(req_s)
  );
  pbus_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(pb_busy_i), .q_o(busy_s)
  );

  pbus_timer #(.WIDTH(TW)) u_settle_tmr (
    .clk(clk), .rst_n(rst_n_s), .load_i(set_ld), .dec_i(set_dec),
    .load_val_i(SETTLE_LD), .zero_o(set_zero)
  );
  pbus_timer #(.WIDTH(TW)) u_tout_tmr (
    .clk(clk), .rst_n(rst_n_s), .load_i(to_ld), .dec_i(to_dec),
    .load_val_i(TOUT_LD), .zero_o(to_zero)
  );

  always_comb begin
    state_d = state_q;
    set_ld  = 1'b0;
    set_dec = 1'b0;
    to_ld   = 1'b0;
    to_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_s && !busy_s) begin
          state_d = ST_SETTLE;
          set_ld  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (!req_s) begin
          state_d = ST_IDLE;
        end else if (set_zero && io_grant_ok_i) begin
          state_d = ST_OFFER;
          to_ld   = 1'b1;
        end else begin
          set_dec = 1'b1;
        end
      end
      ST_OFFER: begin
        if (busy_s)       state_d = ST_HELD;
        else if (to_zero) state_d = ST_IDLE;
        else              to_dec  = 1'b1;
      end
      ST_HELD: begin
        if (!busy_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  assign pb_ack_o    = (state_q == ST_OFFER);
  assign io_active_o = (state_q == ST_OFFER) || (state_q == ST_HELD);

  // Observation counters for the checks below
  logic [TW-1:0] req_run_q, ack_run_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      req_run_q <= '0;
      ack_run_q <= '0;
    end else begin
      if (!req_s)                            req_run_q <= '0;
      else if (req_run_q != TW'(SETTLE_CYC)) req_run_q <= req_run_q + 1'b1;
      if (!pb_ack_o)                         ack_run_q <= '0;
      else if (ack_run_q != TW'(MAXC))       ack_run_q <= ack_run_q + 1'b1;
    end
  end

  // R2
  settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(pb_ack_o) |-> (req_run_q == TW'(SETTLE_CYC)));
  // R4
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(pb_ack_o) |-> $past(io_grant_ok_i));
  // R5
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pb_ack_o && busy_s) |=> !pb_ack_o);
  // R6
  active_cover_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    pb_ack_o |-> io_active_o);
  // R6
  active_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(io_active_o) |-> (!busy_s || $past(pb_ack_o)));
  // R7
  offer_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    pb_ack_o |-> (ack_run_q < TW'(BUSY_TIMEOUT)));
  // R9
  held_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (io_active_o && !pb_ack_o && busy_s) |=> !pb_ack_o);
endmodule

// File: tb/pbus_ack_gen_tb.sv
module pbus_ack_gen_tb_top;
  localparam int SET = 20;
  localparam int BTO = 16;
  localparam int SYN = 2;

  logic clk = 1'b0;
  logic rst_n, req, busy, gok;
  logic ack, act;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pbus_ack_gen #(.SETTLE_CYC(SET), .BUSY_TIMEOUT(BTO), .SYNC_STAGES(SYN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pb_req_i(req), .pb_busy_i(busy),
    .io_grant_ok_i(gok), .pb_ack_o(ack), .io_active_o(act)
  );

  task automatic chk(input string req_tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, actual, expected);
    end
  endtask

  task automatic chk_rng(input string req_tag, input int actual, input int lo, input int hi);
    checks++;
    if (actual < lo || actual > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req_tag, actual, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count cycles until signal reaches value (sampled at negedge)
  task automatic wait_ack(input logic val, input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (ack == val) break;
    end
  endtask

  task automatic wait_act(input logic val, input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (act == val) break;
    end
  endtask

  task automatic idle_out();
    req = 1'b0; busy = 1'b0; gok = 1'b1;
    cyc(SYN + 6);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 1'b0; busy = 1'b0; gok = 1'b1;
    cyc(3);
    chk("R1 ack in reset", int'(ack), 0);
    chk("R1 active in reset", int'(act), 0);
    rst_n = 1'b1;
    cyc(8);
    chk("R1 ack after reset", int'(ack), 0);
    chk("R1 active after reset", int'(act), 0);
  endtask

  task automatic t_basic();
    int n;
    req = 1'b1;
    wait_ack(1'b1, 200, n);
    chk_rng("R2 settle latency", n, SET + SYN, SET + SYN + 2);
    chk("R6 active with ack", int'(act), 1);
    busy = 1'b1;
    wait_ack(1'b0, 20, n);
    chk_rng("R5 ack release on busy", n, 1, SYN + 1);
    chk("R6 active during tenure", int'(act), 1);
    cyc(30);
    chk("R9 no ack during tenure", int'(ack), 0);
    chk("R6 active held", int'(act), 1);
    req = 1'b0; busy = 1'b0;
    wait_act(1'b0, 20, n);
    chk_rng("R6 active drop", n, 1, SYN + 1);
    idle_out();
  endtask

  task automatic t_restart();
    int n;
    req = 1'b1;
    cyc(SET / 2);
    req = 1'b0;
    cyc(SYN + 4);
    chk("R3 no ack after short request", int'(ack), 0);
    req = 1'b1;
    wait_ack(1'b1, 200, n);
    chk_rng("R3 full window after restart", n, SET + SYN, SET + SYN + 2);
    busy = 1'b1;
    cyc(SYN + 3);
    req = 1'b0; busy = 1'b0;
    idle_out();
  endtask

  task automatic t_grant();
    int n;
    gok = 1'b0;
    req = 1'b1;
    cyc(SET * 3);
    chk("R4 ack held without permission", int'(ack), 0);
    gok = 1'b1;
    wait_ack(1'b1, 20, n);
    chk_rng("R4 ack after permission", n, 1, 2);
    busy = 1'b1;
    cyc(SYN + 3);
    req = 1'b0; busy = 1'b0;
    idle_out();
  endtask

  task automatic t_timeout();
    int n;
    int hi;
    req = 1'b1;
    wait_ack(1'b1, 200, n);
    chk_rng("R7 offer starts", n, SET + SYN, SET + SYN + 2);
    req = 1'b0;
    hi = 1;
    while (hi < 200) begin
      @(negedge clk);
      if (!ack) break;
      hi++;
    end
    chk_rng("R7 offer length", hi, BTO - 1, BTO + 1);
    chk("R7 active after timeout", int'(act), 0);
    cyc(SET + 10);
    chk("R7 stays idle", int'(ack), 0);
    idle_out();
  endtask

  task automatic t_busy_block();
    int n;
    busy = 1'b1;
    cyc(SYN + 2);
    req = 1'b1;
    cyc(SET * 3);
    chk("R8 no ack while bus held", int'(ack), 0);
    chk("R8 no active while bus held", int'(act), 0);
    busy = 1'b0;
    wait_ack(1'b1, 200, n);
    chk_rng("R8 full window after busy drop", n, SET + SYN, SET + SYN + 2);
    busy = 1'b1;
    cyc(SYN + 3);
    req = 1'b0; busy = 1'b0;
    idle_out();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_restart();
    t_grant();
    t_timeout();
    t_busy_block();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule